// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port

This block sends and receives asynchronous serial characters and is controlled through a small 8-bit register bus. A mode register sets the options for both directions. It turns each direction on or off, selects a 7-bit or 8-bit character, chooses no parity, even parity or odd parity, and picks one or two stop bits. A single data offset serves both directions. A bus write to that offset loads the transmitter, and that write alone starts a character. A bus read of the same offset returns the last character that was received.

The receiver oversamples its input line using an external baud tick that runs at 16 times the bit rate. The same tick paces the transmitter. The receiver assembles each character in a hidden shift register and copies it into the readable buffer only when the stop bit has been sampled. Parity, framing and overrun problems are recorded in a status register, and a read of that register clears them.

Top module: `aport_top`

## Requirements
- R1: A write to offset 0 while mode bit 0 (transmit enable) is 1 and no frame is in progress starts a frame. The line is low from the next clock, and each bit lasts 16 baud ticks counted after the write. A write with bit 0 clear does nothing.
- R2: A frame is a low start bit, then the data bits least significant first, then an optional parity bit, then one stop bit, or two when mode bit 5 is 1. Stop bits are high. The line rests high between frames.
- R3: When mode bit 2 is 1, characters are 7 bits long and bit 7 of the written value is never sent.
- R4: Mode bit 3 adds a parity bit. Mode bit 4 selects odd parity when 1 and even parity when 0.
- R5: A write to offset 0 during a frame is ignored and does not disturb the frame. Status bit 3 reads 1 while a frame is being sent.
- R6: When mode bit 1 (receive enable) is 1, a completed character is placed in the buffer read at offset 0. Status bit 4 then reads 1, and a read of offset 0 clears it.
- R7: A 7-bit character is placed in buffer bits 0 to 6, and bit 7 reads 0.
- R8: The buffer keeps its old value while a character is being received and changes only once the stop bit is sampled.
- R9: A received parity bit that does not match the selected parity sets status bit 0.
- R10: A stop bit sampled low sets status bit 1.
- R11: A character that completes while status bit 4 is still 1 sets status bit 2. The newer character replaces the buffer.
- R12: A read of the status register at offset 2 clears status bits 0 to 2.
- R13: A low pulse that is high again by the middle of the start bit is rejected. No character results, and the receiver is ready for the next real start bit.
- R14: After reset the line is high, and both the mode register (offset 1) and the status register read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle pulse at 16 times the bit rate |
| busAddr | input | 2 | Register offset: 0 data, 1 mode, 2 status |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe; side effects occur at the clock edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, zero when busRd is low |
| rxLine | input | 1 | Serial input |
| txLine | output | 1 | Serial output |

## Verification
The hardest states to reach from the ports are on the receive side. One is an overrun, which needs two full characters to arrive with no read of the data offset between them. Another is a false start, where the line must go high again before the receiver's mid-bit sample. The third is a mid-character read, which must return the previous character.

The bench drives the serial input from its own bit-timed task and controls exactly how many clocks each level is held. It sends two characters back to back without reading to cause an overrun. It pulses the line low for three baud ticks to fake a start. It reads the buffer concurrently, partway through a frame, to check that the old character is still there. A held-low stop bit ends early so that the following idle period cannot be mistaken for a new start.

// File: rtl/aport_pkg.sv
package aport_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  // mode register, bit 0 at the right
  typedef struct packed {
    logic stop2;
    logic parOdd;
    logic parEn;
    logic len7;
    logic rxEn;
    logic txEn;
  } mode_t;

  // control to datapath strobes
  typedef struct packed {
    logic txLoad;
    logic txNext;
    logic rxClear;
    logic rxData;
    logic rxPar;
    logic rxStop;
  } strobe_t;
endpackage

// File: rtl/aport_ctrl.sv
module aport_ctrl
  import aport_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    baudTick,
  input  logic    dataWr,
  input  logic    rxBit,
  input  mode_t   mode,
  output logic    txBusy,
  output strobe_t strb
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int IDX_W = $clog2(DATA_W + 4);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE / 2 - 1);

  logic [CNT_W-1:0] txCnt, rxCnt;
  logic [IDX_W-1:0] txIdx, rxIdx, txLast, rxLast, dataBits;
  logic rxBusy, txStart, txBitEnd, rxMid;

  always_comb begin
    dataBits = IDX_W'(DATA_W) - IDX_W'(mode.len7);
    rxLast   = dataBits + IDX_W'(mode.parEn) + IDX_W'(1);
    txLast   = rxLast + IDX_W'(mode.stop2);
  end

  assign txStart  = dataWr && mode.txEn && !txBusy;
  assign txBitEnd = txBusy && baudTick && (txCnt == CNT_LAST);
  assign rxMid    = rxBusy && baudTick && (rxCnt == CNT_MID);

  // transmit sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txCnt  <= '0;
      txIdx  <= '0;
    end else if (txStart) begin
      txBusy <= 1'b1;
      txCnt  <= '0;
      txIdx  <= '0;
    end else if (txBusy && baudTick) begin
      txCnt <= txCnt + 1'b1;
      if (txCnt == CNT_LAST) begin
        if (txIdx == txLast) txBusy <= 1'b0;
        else                 txIdx  <= txIdx + 1'b1;
      end
    end
  end

  // receive sequencing: detecting tick is sample 0 of the start bit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBusy <= 1'b0;
      rxCnt  <= '0;
      rxIdx  <= '0;
    end else if (!rxBusy) begin
      if (strb.rxClear) begin
        rxBusy <= 1'b1;
        rxCnt  <= CNT_W'(1);
        rxIdx  <= '0;
      end
    end else if (baudTick) begin
      rxCnt <= rxCnt + 1'b1;
      if (rxCnt == CNT_LAST) rxIdx <= rxIdx + 1'b1;
      if (rxMid && (((rxIdx == '0) && rxBit) || (rxIdx == rxLast))) rxBusy <= 1'b0;
    end
  end

  always_comb begin
    strb.txLoad  = txStart;
    strb.txNext  = txBitEnd && (txIdx != txLast);
    strb.rxClear = !rxBusy && baudTick && mode.rxEn && !rxBit;
    strb.rxData  = rxMid && (rxIdx != '0) && (rxIdx <= dataBits);
    strb.rxPar   = rxMid && mode.parEn && (rxIdx == dataBits + IDX_W'(1));
    strb.rxStop  = rxMid && (rxIdx == rxLast);
  end
endmodule

// File: rtl/aport_dp.sv
module aport_dp
  import aport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxLine,
  output logic              txLine,
  input  strobe_t           strb,
  input  logic              txBusy,
  output logic              rxBit,
  output logic              dataWr,
  output mode_t             modeQ
);
  localparam int FRAME_W = DATA_W + 4;

  logic [FRAME_W-1:0] txFrame;
  logic [1:0]         rxSync;
  logic [DATA_W-1:0]  rxShift, rxBuf;
  logic rxAcc, parBad, errPar, errFrm, errOvr, rxFull;
  logic dataRd, statRd;

  function automatic logic [FRAME_W-1:0] buildFrame(input logic [DATA_W-1:0] d, input mode_t m);
    logic [FRAME_W-1:0] f;
    logic p;
    f    = '1;
    f[0] = 1'b0;
    p    = m.parOdd;
    for (int i = 0; i < DATA_W; i++) begin
      if (!(m.len7 && (i == DATA_W - 1))) begin
        f[i+1] = d[i];
        p      = p ^ d[i];
      end
    end
    if (m.parEn) f[DATA_W + 1 - int'(m.len7)] = p;
    return f;
  endfunction

  assign dataWr = busWr && (busAddr == ADDR_DATA);
  assign dataRd = busRd && (busAddr == ADDR_DATA);
  assign statRd = busRd && (busAddr == ADDR_STAT);
  assign rxBit  = rxSync[1];
  assign txLine = txBusy ? txFrame[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= '0;
      txFrame <= '1;
      rxSync  <= 2'b11;
    end else begin
      rxSync <= {rxSync[0], rxLine};
      if (busWr && (busAddr == ADDR_MODE)) modeQ <= mode_t'(busWdata[5:0]);
      if (strb.txLoad)      txFrame <= buildFrame(busWdata, modeQ);
      else if (strb.txNext) txFrame <= {1'b1, txFrame[FRAME_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      rxBuf   <= '0;
      rxAcc   <= 1'b0;
      parBad  <= 1'b0;
    end else begin
      if (strb.rxClear) begin
        rxAcc  <= 1'b0;
        parBad <= 1'b0;
      end
      if (strb.rxData) begin
        rxShift <= {rxBit, rxShift[DATA_W-1:1]};
        rxAcc   <= rxAcc ^ rxBit;
      end
      if (strb.rxPar) parBad <= rxAcc ^ rxBit ^ modeQ.parOdd;
      if (strb.rxStop) rxBuf <= modeQ.len7 ? {1'b0, rxShift[DATA_W-1:1]} : rxShift;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errPar <= 1'b0;
      errFrm <= 1'b0;
      errOvr <= 1'b0;
      rxFull <= 1'b0;
    end else begin
      if (statRd) begin
        errPar <= 1'b0;
        errFrm <= 1'b0;
        errOvr <= 1'b0;
      end
      if (dataRd) rxFull <= 1'b0;
      if (strb.rxStop) begin
        rxFull <= 1'b1;
        if (parBad)            errPar <= 1'b1;
        if (!rxBit)            errFrm <= 1'b1;
        if (rxFull && !dataRd) errOvr <= 1'b1;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      unique case (busAddr)
        ADDR_DATA: busRdata      = rxBuf;
        ADDR_MODE: busRdata[5:0] = modeQ;
        ADDR_STAT: busRdata[4:0] = {rxFull, txBusy, errOvr, errFrm, errPar};
        default:   busRdata      = '0;
      endcase
    end
  end
endmodule

// File: rtl/aport_top.sv
module aport_top
  import aport_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              rxLine,
  output logic              txLine
);
  strobe_t strb;
  mode_t   modeQ;
  logic    txBusy, rxBit, dataWr;

  aport_ctrl #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .dataWr(dataWr),
    .rxBit(rxBit), .mode(modeQ), .txBusy(txBusy), .strb(strb)
  );

  aport_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .rxLine(rxLine), .txLine(txLine),
    .strb(strb), .txBusy(txBusy), .rxBit(rxBit), .dataWr(dataWr), .modeQ(modeQ)
  );
endmodule

// File: rtl/aport_chk.sv
module aport_chk
  import aport_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              baudTick,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic              txLine,
  input logic              txBusy,
  input logic              txEn,
  input strobe_t           strb
);
  AST_TX_START: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && (busAddr == ADDR_DATA) && txEn && !txBusy) |=> (txBusy && !txLine)); // R1
  AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && !baudTick) |=> $stable(txLine)); // R1
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txLine); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && !baudTick) |=> txBusy); // R5
  AST_RX_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rxClear, strb.rxData, strb.rxPar, strb.rxStop})); // R8
endmodule

bind aport_top aport_chk u_chk (
  .clk(clk), .rstN(rstN), .baudTick(baudTick), .busWr(busWr), .busAddr(busAddr),
  .txLine(txLine), .txBusy(txBusy), .txEn(modeQ.txEn), .strb(strb)
);

// File: tb/aport_top_tb.sv
module aport_top_tb;
  logic clk = 1'b0, rstN = 1'b0, baudTick = 1'b0, busWr = 1'b0, busRd = 1'b0, rxLine = 1'b1;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic txLine;
  int nCmp = 0, nBad = 0, tdiv = 0;
  logic [7:0] modeSh = '0;
  bit done = 0;

  always #10 clk = ~clk;

  aport_top u_dut (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata), .rxLine(rxLine), .txLine(txLine)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    baudTick <= (tdiv == 0);
  end

  // behavioural transmit model
  bit mBits[$];
  int mIdx = 0, mCnt = 0;
  bit mBusy = 0;
  always @(posedge clk) begin
    if (!rstN) mBusy = 0;
    else if (busWr && busAddr == 2'd0 && modeSh[0] && !mBusy) begin
      bit p;
      mBits.delete();
      mBits.push_back(1'b0);
      p = modeSh[4];
      for (int i = 0; i < (modeSh[2] ? 7 : 8); i++) begin
        mBits.push_back(busWdata[i]);
        p ^= busWdata[i];
      end
      if (modeSh[3]) mBits.push_back(p);
      mBits.push_back(1'b1);
      if (modeSh[5]) mBits.push_back(1'b1);
      mIdx = 0; mCnt = 0; mBusy = 1;
    end else if (mBusy && baudTick) begin
      if (mCnt == 15) begin
        mCnt = 0;
        if (mIdx == mBits.size() - 1) mBusy = 0;
        else mIdx++;
      end else mCnt++;
    end
  end

  always @(negedge clk)
    if (rstN && !done) begin
      bit e;
      e = mBusy ? mBits[mIdx] : 1'b1;
      check(txLine === e, "R1 R2 R3 R4 R5 txLine", int'(txLine), int'(e));
    end

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 0;
    if (a == 2'd1) modeSh = d;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); busRd = 1; busAddr = a;
    #2 v = busRdata;
    @(negedge clk); busRd = 0;
  endtask

  task automatic waitTx();
    while (mBusy) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic sendRx(input logic [7:0] d, input int nb, input bit pe, input bit odd,
                        input bit badPar, input bit badStop);
    bit p;
    p = odd;
    @(negedge clk); rxLine = 0; repeat (64) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxLine = d[i]; p ^= d[i];
      repeat (64) @(negedge clk);
    end
    if (pe) begin rxLine = p ^ badPar; repeat (64) @(negedge clk); end
    rxLine = !badStop;
    repeat (badStop ? 44 : 64) @(negedge clk);
    rxLine = 1; repeat (96) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(txLine === 1'b1, "R14 line idle", int'(txLine), 1);
    rdReg(2'd2, v); check(v == 8'h00, "R14 status", v, 0);
    rdReg(2'd1, v); check(v == 8'h00, "R14 mode", v, 0);

    // transmit disabled: write dropped (line compared each clock)
    wrReg(2'd0, 8'h0F); repeat (100) @(negedge clk);

    // 8 bits, no parity, one stop
    wrReg(2'd1, 8'h01); wrReg(2'd0, 8'hA5);
    rdReg(2'd2, v); check(v[3] == 1'b1, "R5 busy set", v[3], 1);
    wrReg(2'd0, 8'h00); // ignored during frame
    waitTx();
    rdReg(2'd2, v); check(v[3] == 1'b0, "R5 busy clear", v[3], 0);

    // 7 bits, even parity: bit 7 not sent (R3 R4)
    wrReg(2'd1, 8'h0D); wrReg(2'd0, 8'hC3); waitTx();
    // 8 bits, odd parity, two stops (R2 R4)
    wrReg(2'd1, 8'h39); wrReg(2'd0, 8'h5A); waitTx();

    // receive 8N1
    wrReg(2'd1, 8'h02);
    sendRx(8'h3C, 8, 0, 0, 0, 0);
    rdReg(2'd2, v); check(v == 8'h10, "R6 ready", v, 8'h10);
    rdReg(2'd0, v); check(v == 8'h3C, "R6 data", v, 8'h3C);
    rdReg(2'd2, v); check(v == 8'h00, "R6 ready cleared", v, 0);

    // buffer holds during reception
    fork
      sendRx(8'h81, 8, 0, 0, 0, 0);
      begin
        repeat (300) @(negedge clk);
        rdReg(2'd0, v); check(v == 8'h3C, "R8 old value mid-frame", v, 8'h3C);
      end
    join
    rdReg(2'd0, v); check(v == 8'h81, "R8 new value", v, 8'h81);

    // 7 bits with even parity
    wrReg(2'd1, 8'h0E);
    sendRx(8'hD3, 7, 1, 0, 0, 0);
    rdReg(2'd2, v); check(v == 8'h10, "R7 no error", v, 8'h10);
    rdReg(2'd0, v); check(v == 8'h53, "R7 msb zero", v, 8'h53);

    // parity error
    sendRx(8'h2B, 7, 1, 0, 1, 0);
    rdReg(2'd2, v); check(v[0] == 1'b1, "R9 parity flag", v, 8'h11);
    rdReg(2'd2, v); check(v[2:0] == 3'b000, "R12 cleared", v, 8'h10);
    rdReg(2'd0, v); check(v == 8'h2B, "R9 data", v, 8'h2B);

    // framing error
    wrReg(2'd1, 8'h02);
    sendRx(8'h66, 8, 0, 0, 0, 1);
    rdReg(2'd2, v); check(v == 8'h12, "R10 framing flag", v, 8'h12);
    rdReg(2'd0, v); check(v == 8'h66, "R10 data", v, 8'h66);

    // overrun
    sendRx(8'h11, 8, 0, 0, 0, 0);
    sendRx(8'h22, 8, 0, 0, 0, 0);
    rdReg(2'd2, v); check(v == 8'h14, "R11 overrun flag", v, 8'h14);
    rdReg(2'd0, v); check(v == 8'h22, "R11 newer kept", v, 8'h22);
    rdReg(2'd2, v); check(v == 8'h00, "R12 all cleared", v, 0);

    // false start
    @(negedge clk); rxLine = 0; repeat (12) @(negedge clk); rxLine = 1;
    repeat (200) @(negedge clk);
    rdReg(2'd2, v); check(v == 8'h00, "R13 no character", v, 0);
    sendRx(8'h5E, 8, 0, 0, 0, 0);
    rdReg(2'd0, v); check(v == 8'h5E, "R13 recovered", v, 8'h5E);

    repeat (10) @(negedge clk);
    finishRun();
  end
endmodule